// File: doc/BRIEF.md
# Event-Clocked General-Purpose Output Register

This block holds four general-purpose output bits that can be loaded in two ways. The host can write the whole nibble over a small register bus. Each bit can also be loaded from its own event port: a per-bit clock selector picks which event edge loads the bit, and a per-bit data selector picks the value loaded. That value is a constant one, a constant zero, the inverse of the bit (toggle), or, on the two low bits only, an external data line. The result is that a bit can be set, cleared or toggled in step with external or internal events without host involvement.

A separate four-bit source selector decides what drives the single output pin. It can drive the pin from one of four channel clock taps (generated elsewhere), from one of the four register bits, or hold the pin low. The event and alternate clock and data inputs are asynchronous. They pass through a two-flop synchronizer, and a rising edge of an event becomes a one-cycle load enable.

Top module: `egpo_top`

## Requirements
- R1: After reset, all four registers (output value, clock select, data select, source select) read as zero and `gpo_pin` is low.
- R2: Host writes (`wr_en` high at a clock edge) load the register chosen by `addr`: 0 = output value (bits 3:0), 1 = clock select (bits 7:0), 2 = data select (bits 7:0), 3 = source select (bits 3:0). `rdata` returns the current contents of the addressed register, with unused upper bits read as zero. Address 0 reads back the current bits whichever port last loaded them.
- R3: Output bit i has a clock field at clock-select bits [2i+1:2i]. Code 00 means no clock, and events never change that bit.
- R4: Clock code 01 selects `evt_in[0]` and code 10 selects `evt_in[1]`. When the selected input goes from low to high (driven just after a clock edge), the bit is loaded at the third following rising clock edge.
- R5: Clock code 11 selects `io3_clk[i]` for bits 1 and 0. For bits 3 and 2, code 11 is reserved and acts as no clock.
- R6: Output bit i has a data field at data-select bits [2i+1:2i]. Code 00 loads 1, code 01 loads 0, and code 10 loads the inverse of the bit, so the bit toggles on each selected event.
- R7: Data code 11 loads the synchronized `io3_dat[i]` for bits 1 and 0. For bits 3 and 2 it is reserved and leaves the bit unchanged.
- R8: If a host write to address 0 and an event load of a bit fall in the same cycle, the host value is stored.
- R9: Source codes 1000, 1001, 1010 and 1011 drive `gpo_pin` from `tap_tx1x_a`, `tap_tx16x_a`, `tap_rx16x_a` and `tap_tx16x_b` respectively.
- R10: Source codes 1100, 1101, 1110 and 1111 drive `gpo_pin` from output bits 3, 2, 1 and 0 respectively.
- R11: Source codes 0000 to 0111 drive `gpo_pin` low.
- R12: An event input held high loads the bit only once. Each rising edge gives exactly one load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 2 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Readback of the addressed register |
| evt_in | input | 2 | Asynchronous event inputs 0 and 1 |
| io3_clk | input | 2 | Alternate event clocks for bits 1 and 0 |
| io3_dat | input | 2 | Alternate data for bits 1 and 0 |
| tap_tx1x_a | input | 1 | Channel a transmit clock, 1x |
| tap_tx16x_a | input | 1 | Channel a transmit clock, 16x |
| tap_rx16x_a | input | 1 | Channel a receive clock, 16x |
| tap_tx16x_b | input | 1 | Channel b transmit clock, 16x |
| gpo_pin | output | 1 | Selected output pin |

## Verification
The assertions assume that every event and alternate clock input stays at each level for at least one full system clock after synchronization. Under that assumption a rising edge yields one isolated enable pulse, never two in consecutive cycles. They also assume that the alternate data line is stable around its clock edge, so the loaded value is well defined. The stimulus holds every event level for four cycles and sets `io3_dat` several cycles before any clock edge that uses it. The only close timing in the stimulus is the deliberate collision, in which the host write is placed exactly in the enable cycle.

// File: rtl/egpo_pkg.sv
package egpo_pkg;
  localparam int NBITS   = 4;
  localparam int FIELD_W = 2;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;
  localparam int NTAPS   = 4;
  localparam int SRC_W   = 4;
  localparam int NALT    = 2;

  localparam logic [ADDR_W-1:0] A_VAL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CSEL = 2'd1;
  localparam logic [ADDR_W-1:0] A_DSEL = 2'd2;
  localparam logic [ADDR_W-1:0] A_SRC  = 2'd3;

  typedef enum logic [FIELD_W-1:0] {
    CK_NONE = 2'b00,
    CK_EV0  = 2'b01,
    CK_EV1  = 2'b10,
    CK_ALT  = 2'b11
  } clk_code_e;

  typedef enum logic [FIELD_W-1:0] {
    DT_ONE  = 2'b00,
    DT_ZERO = 2'b01,
    DT_INV  = 2'b10,
    DT_ALT  = 2'b11
  } dat_code_e;
endpackage

// File: rtl/egpo_sync.sv
module egpo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st_q [STAGES];
  logic [W-1:0] st_d [STAGES];

  always_comb begin
    st_d[0] = din;
    for (int k = 1; k < STAGES; k++) st_d[k] = st_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st_q[k] <= '0;
    end else begin
      for (int k = 0; k < STAGES; k++) st_q[k] <= st_d[k];
    end
  end

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/egpo_rise.sv
module egpo_rise #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  // R12: a held level yields one enable, never a pulse train
  for (genvar g = 0; g < W; g++) begin : g_chk
    assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> !rise[g]);
  end
endmodule

// File: rtl/egpo_bit_cell.sv
module egpo_bit_cell
  import egpo_pkg::*;
#(
  parameter bit HAS_ALT = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_ld,
  input  logic               host_d,
  input  logic [FIELD_W-1:0] clk_code,
  input  logic [FIELD_W-1:0] dat_code,
  input  logic [1:0]         ev_pulse,
  input  logic               alt_pulse,
  input  logic               alt_data,
  output logic               q
);
  logic fire;
  logic d_val;
  logic d_ok;
  logic q_d;

  always_comb begin
    unique case (clk_code_e'(clk_code))
      CK_EV0:  fire = ev_pulse[0];
      CK_EV1:  fire = ev_pulse[1];
      CK_ALT:  fire = HAS_ALT ? alt_pulse : 1'b0;
      default: fire = 1'b0;
    endcase
  end

  always_comb begin
    d_ok = 1'b1;
    unique case (dat_code_e'(dat_code))
      DT_ONE:  d_val = 1'b1;
      DT_ZERO: d_val = 1'b0;
      DT_INV:  d_val = ~q;
      default: begin
        d_val = HAS_ALT ? alt_data : q;
        d_ok  = HAS_ALT;
      end
    endcase
  end

  always_comb begin
    if (host_ld)            q_d = host_d;
    else if (fire && d_ok)  q_d = d_val;
    else                    q_d = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  // R3: no clock selected, bit holds
  assert_noclk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ld && clk_code == 2'b00) |=> q == $past(q));
  // R6: toggle mode inverts the bit on every enabled event
  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ld && fire && dat_code == 2'b10) |=> q != $past(q));
  // R8: host load takes priority
  assert_host_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_ld |=> q == $past(host_d));

  if (!HAS_ALT) begin : g_resv
    // R5: reserved clock code on the upper bits acts as no clock
    assert_resv_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_ld && clk_code == 2'b11) |=> q == $past(q));
    // R7: reserved data code on the upper bits leaves the bit alone
    assert_resv_dat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_ld && dat_code == 2'b11) |=> q == $past(q));
  end
endmodule

// File: rtl/egpo_src_mux.sv
module egpo_src_mux
  import egpo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src,
  input  logic [NBITS-1:0] q,
  input  logic [NTAPS-1:0] taps,
  output logic             pin
);
  logic [1:0] qi;

  always_comb begin
    qi = 2'(NBITS - 1) - src[1:0];
    if (!src[3])     pin = 1'b0;
    else if (src[2]) pin = q[qi];
    else             pin = taps[src[1:0]];
  end

  // R11: reserved source codes keep the pin low
  assert_resv_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !src[3] |-> !pin);
endmodule

// File: rtl/egpo_top.sv
module egpo_top
  import egpo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [1:0]        evt_in,
  input  logic [NALT-1:0]   io3_clk,
  input  logic [NALT-1:0]   io3_dat,
  input  logic              tap_tx1x_a,
  input  logic              tap_tx16x_a,
  input  logic              tap_rx16x_a,
  input  logic              tap_tx16x_b,
  output logic              gpo_pin
);
  localparam int NSYNC = 2 + 2 * NALT;
  localparam int NEDGE = 2 + NALT;

  logic [1:0]        rst_q;
  logic              rst_i;
  logic [DATA_W-1:0] csel_q, csel_d;
  logic [DATA_W-1:0] dsel_q, dsel_d;
  logic [SRC_W-1:0]  src_q, src_d;
  logic [NBITS-1:0]  val;
  logic [NSYNC-1:0]  lvl;
  logic [NEDGE-1:0]  rise;
  logic              ld_val, ld_csel, ld_dsel, ld_src;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  assign ld_val  = wr_en && (addr == A_VAL);
  assign ld_csel = wr_en && (addr == A_CSEL);
  assign ld_dsel = wr_en && (addr == A_DSEL);
  assign ld_src  = wr_en && (addr == A_SRC);

  always_comb begin
    csel_d = ld_csel ? wdata : csel_q;
    dsel_d = ld_dsel ? wdata : dsel_q;
    src_d  = ld_src  ? wdata[SRC_W-1:0] : src_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      csel_q <= '0;
      dsel_q <= '0;
      src_q  <= '0;
    end else begin
      csel_q <= csel_d;
      dsel_q <= dsel_d;
      src_q  <= src_d;
    end
  end

  egpo_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i),
    .din({io3_dat, io3_clk, evt_in}),
    .dout(lvl)
  );

  egpo_rise #(.W(NEDGE)) u_rise (
    .clk(clk), .rst_n(rst_i),
    .lvl(lvl[NEDGE-1:0]),
    .rise(rise)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    localparam bit ALT = (i < NALT);
    logic a_pulse, a_data;
    if (ALT) begin : g_alt
      assign a_pulse = rise[2 + i];
      assign a_data  = lvl[NEDGE + i];
    end else begin : g_noalt
      assign a_pulse = 1'b0;
      assign a_data  = 1'b0;
    end
    egpo_bit_cell #(.HAS_ALT(ALT)) u_cell (
      .clk(clk), .rst_n(rst_i),
      .host_ld(ld_val), .host_d(wdata[i]),
      .clk_code(csel_q[FIELD_W*i +: FIELD_W]),
      .dat_code(dsel_q[FIELD_W*i +: FIELD_W]),
      .ev_pulse(rise[1:0]),
      .alt_pulse(a_pulse), .alt_data(a_data),
      .q(val[i])
    );
  end

  egpo_src_mux u_mux (
    .clk(clk), .rst_n(rst_i),
    .src(src_q), .q(val),
    .taps({tap_tx16x_b, tap_rx16x_a, tap_tx16x_a, tap_tx1x_a}),
    .pin(gpo_pin)
  );

  always_comb begin
    unique case (addr)
      A_VAL:   rdata = {{(DATA_W-NBITS){1'b0}}, val};
      A_CSEL:  rdata = csel_q;
      A_DSEL:  rdata = dsel_q;
      default: rdata = {{(DATA_W-SRC_W){1'b0}}, src_q};
    endcase
  end

  // R2: host write lands in the selected configuration register
  assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_en && addr == A_CSEL) |=> csel_q == $past(wdata));
endmodule

// File: tb/tb_egpo_top.sv
module tb_egpo_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [1:0] evt_in, io3_clk, io3_dat;
  logic       t0, t1, t2, t3;
  logic       gpo_pin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  egpo_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_in(evt_in), .io3_clk(io3_clk), .io3_dat(io3_dat),
    .tap_tx1x_a(t0), .tap_tx16x_a(t1), .tap_rx16x_a(t2), .tap_tx16x_b(t3),
    .gpo_pin(gpo_pin)
  );

  typedef struct packed {
    logic [3:0] init;
    logic [7:0] csel;
    logic [7:0] dsel;
    logic [1:0] ev;
    logic [1:0] io3c;
    logic [1:0] io3d;
    logic [3:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{4'h0, 8'h55, 8'h00, 2'b01, 2'b00, 2'b00, 4'hF, 4'd4},  // R4 event 0 sets all
    '{4'h0, 8'h55, 8'h00, 2'b10, 2'b00, 2'b00, 4'h0, 4'd4},  // R4 event 1 not selected
    '{4'hF, 8'hAA, 8'h55, 2'b10, 2'b00, 2'b00, 4'h0, 4'd4},  // R4 event 1 clears all
    '{4'h5, 8'h55, 8'hAA, 2'b01, 2'b00, 2'b00, 4'hA, 4'd6},  // R6 toggle
    '{4'h5, 8'h55, 8'h1A, 2'b01, 2'b00, 2'b00, 4'hA, 4'd6},  // R6 set/clear/toggle mix
    '{4'h6, 8'h00, 8'h00, 2'b11, 2'b11, 2'b00, 4'h6, 4'd3},  // R3 no clock
    '{4'h0, 8'hFF, 8'h00, 2'b11, 2'b11, 2'b00, 4'h3, 4'd5},  // R5 alt clocks low bits only
    '{4'h0, 8'hFF, 8'h00, 2'b00, 2'b10, 2'b00, 4'h2, 4'd5},  // R5 alt clock bit 1 alone
    '{4'hA, 8'h55, 8'hFF, 2'b01, 2'b00, 2'b01, 4'h9, 4'd7},  // R7 alt data, upper reserved
    '{4'h4, 8'hFF, 8'hFF, 2'b00, 2'b11, 2'b10, 4'h6, 4'd7},  // R7 alt data with alt clocks
    '{4'h0, 8'h93, 8'h00, 2'b01, 2'b01, 2'b00, 4'h5, 4'd4}   // R4 per-bit clock mix
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    evt_in = '0; io3_clk = '0; io3_dat = '0;
    {t3, t2, t1, t0} = 4'b0000;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk("R1 reset readback", r, 8'h00);
    end
    chk("R1 reset pin", {7'd0, gpo_pin}, 8'h00);

    // R2 write and readback, unused upper bits read zero
    wr(2'd0, 8'hF9); rd(2'd0, r); chk("R2 value reg", r, 8'h09);
    wr(2'd1, 8'hC3); rd(2'd1, r); chk("R2 clock select", r, 8'hC3);
    wr(2'd2, 8'h3C); rd(2'd2, r); chk("R2 data select", r, 8'h3C);
    wr(2'd3, 8'h52); rd(2'd3, r); chk("R2 source select", r, 8'h02);

    // vector table: event loads, readback through address 0 (R2)
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, {4'h0, VEC[i].init});
      wr(2'd1, VEC[i].csel);
      wr(2'd2, VEC[i].dsel);
      io3_dat = VEC[i].io3d;
      idle(4);
      evt_in = VEC[i].ev; io3_clk = VEC[i].io3c;
      idle(4);
      evt_in = '0; io3_clk = '0;
      idle(4);
      rd(2'd0, r);
      checks++;
      if (r[3:0] !== VEC[i].exp) begin
        errors++;
        $display("FAIL R%0d row %0d actual=%h expected=%h", VEC[i].req, i, r[3:0], VEC[i].exp);
      end
    end

    // R12 held event toggles once only
    wr(2'd0, 8'h00); wr(2'd1, 8'h55); wr(2'd2, 8'hAA);
    idle(2);
    evt_in = 2'b01;
    idle(12);
    rd(2'd0, r); chk("R12 held event single load", r, 8'h0F);
    evt_in = 2'b00;
    idle(4);
    rd(2'd0, r); chk("R12 falling edge no load", r, 8'h0F);

    // R4 latency: load lands at the third rising edge after the input rises
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);
    addr = 2'd0;
    @(negedge clk); evt_in = 2'b01;
    @(negedge clk); @(negedge clk);
    #1 chk("R4 not yet loaded", rdata, 8'h00);
    @(negedge clk);
    #1 chk("R4 loaded on third edge", rdata, 8'h0F);
    evt_in = 2'b00;
    idle(4);

    // R8 host write collides with event enable
    wr(2'd0, 8'h00);
    @(negedge clk); evt_in = 2'b01;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 8'h04;
    @(negedge clk); wr_en = 1'b0;
    idle(3);
    evt_in = 2'b00;
    idle(4);
    rd(2'd0, r); chk("R8 host wins collision", r, 8'h04);

    // R9 clock taps on the pin, two tap patterns
    for (int p = 0; p < 2; p++) begin
      {t3, t2, t1, t0} = (p == 0) ? 4'b0101 : 4'b1010;
      for (int c = 0; c < 4; c++) begin
        wr(2'd3, 8'(8 + c));
        #1 chk("R9 tap select", {7'd0, gpo_pin}, {7'd0, p == 0 ? ~c[0] : c[0]});
      end
    end

    // R10 register bits on the pin
    wr(2'd0, 8'h06);
    for (int c = 0; c < 4; c++) begin
      wr(2'd3, 8'(12 + c));
      #1 chk("R10 bit select", {7'd0, gpo_pin}, {7'd0, (c == 1 || c == 2) ? 1'b1 : 1'b0});
    end
    wr(2'd0, 8'h09);
    wr(2'd3, 8'h0C);
    #1 chk("R10 bit 3 after reload", {7'd0, gpo_pin}, 8'h01);

    // R11 reserved source codes hold the pin low
    {t3, t2, t1, t0} = 4'b1111;
    wr(2'd0, 8'h0F);
    for (int c = 0; c < 8; c++) begin
      wr(2'd3, 8'(c));
      #1 chk("R11 reserved low", {7'd0, gpo_pin}, 8'h00);
    end

    finish_run();
  end
endmodule